// File: doc/BRIEF.md
# Flash Command Interface with Status Register

This block is the control side of a parallel flash device. A host writes command bytes on a strobed bus, and the block turns them into one of eight operations: select the array, status or identification data for reads, start a program, start an erase, clear the error flags, suspend an erase and resume it. Program and erase run under a simplified automatic controller. That controller applies fixed-length pulses, counts them against a parameterized limit and samples a verify-pass input at the end of each pulse. The memory cells, the high-voltage generation and real time are outside the block.

The host sees two results. `rd_sel` tells the surrounding read path which data source to drive. `stat_o` is an 8-bit status byte, captured on every accepted read strobe. A power-down pin puts the block to sleep and returns it to array reads. After the pin is released, commands are accepted after a short delay and reads after a longer one.

The controller states are READY (idle), PSET (program set-up), ESET (erase set-up), PRUN (program pulsing), ERUN (erase pulsing), ESUSP (erase suspended) and SLEEP (power-down). The transitions are:
- READY to PSET on 0x40, and READY to ESET on 0x20.
- PSET to PRUN on any data byte, or PSET to READY when the supply is low.
- ESET to ERUN on 0xD0, or ESET to READY on any other byte or when the supply is low.
- PRUN to READY on verify pass or at the last pulse.
- ERUN to READY on verify pass or at the last pulse, and ERUN to ESUSP on 0xB0.
- ESUSP to ERUN on 0xD0.
- Any state to SLEEP while `pd_n` is low, and SLEEP to READY once it is high.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset `rd_sel` is 0 (array) and `stat_o` is 8'h80.
- R2: In READY or ESUSP, an accepted write of 0xFF, 0x70 or 0x90 sets `rd_sel` to 0 (array), 1 (status) or 2 (identification) at that clock edge. In READY, the bytes 0xB0 and 0xD0 are ignored.
- R3: An accepted read strobe loads `stat_o` with the live status at that edge, including while an operation runs. The fields are: bit 7 ready (1 = idle), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply fault. Bits 2..0 always read 0.
- R4: Program is 0x40 followed by any data byte. The second write starts PRUN, sets `rd_sel` to 1 and clears bit 7. A verify pass at a pulse end returns the block to READY without errors.
- R5: If verify never passes in PROG_MAX pulses of PULSE_CYC cycles, bit 4 is set. For a confirm sampled at edge B, a read at edge B+PROG_MAX*PULSE_CYC still shows busy, and the next read shows ready.
- R6: Erase is 0x20 followed by 0xD0. It runs in ERUN with bit 7 at 0 and ends in READY without errors on a verify pass.
- R7: If verify never passes in ERASE_MAX pulses, bit 5 is set and the block returns to READY.
- R8: In ESET, any byte other than 0xD0 sets bits 5 and 4, returns to READY and sets `rd_sel` to 1.
- R9: If `vpp_low` is high at the second write of a program or erase, bit 3 is set, no pulses run, and the block is ready at once.
- R10: 0x50 clears bits 5, 4 and 3 and leaves `rd_sel` unchanged.
- R11: 0xB0 in ERUN stops pulsing and sets bits 7 and 6. While suspended, no pulse completes and no error is set. 0xD0 resumes the erase and clears bits 6 and 7.
- R12: While `pd_n` is low, `rd_sel` is 0, `stat_o` is 8'h80 and all error bits are cleared.
- R13: After `pd_n` rises at edge F0, command writes are ignored until edge F0+CMD_WAKE and read strobes until edge F0+READ_WAKE.
- R14: With `ce` low, command writes and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce | input | 1 | Chip enable for writes and reads |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command or program data byte |
| rd_stb | input | 1 | Read strobe, captures status |
| vpp_low | input | 1 | Programming supply below minimum |
| pd_n | input | 1 | Active-low power-down |
| verify_ok | input | 1 | Verify pass, sampled at each pulse end |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identification |
| stat_o | output | 8 | Status byte captured on the last accepted read |

## Verification
A command write changes `rd_sel` at the edge that samples it, so the bench checks it at the following falling edge. A read strobe captures the status as it stood before that edge, so a completion at edge E is first visible to a read at edge E+1. The failed-program check therefore reads at every edge up to confirm+PROG_MAX*PULSE_CYC expecting busy, and reads once more expecting ready. The wake-up checks place their commands and reads several edges away from the CMD_WAKE and READ_WAKE boundaries, counting falling edges from the release of `pd_n`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
    localparam logic [7:0] OP_RD_STAT  = 8'h70;
    localparam logic [7:0] OP_RD_SIG   = 8'h90;
    localparam logic [7:0] OP_ERS_SET  = 8'h20;
    localparam logic [7:0] OP_PRG_SET  = 8'h40;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_CLR_STAT = 8'h50;
    localparam logic [7:0] OP_SUSPEND  = 8'hB0;

    typedef enum logic [3:0] {
        C_NONE, C_RD_ARRAY, C_RD_STAT, C_RD_SIG, C_ERS_SET,
        C_PRG_SET, C_CONFIRM, C_CLR_STAT, C_SUSPEND
    } cmd_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_SIG    = 2'd2
    } rmode_t;

    typedef enum logic [2:0] {
        S_READY, S_PSET, S_ESET, S_PRUN, S_ERUN, S_ESUSP, S_SLEEP
    } fsm_t;

    typedef struct packed {
        logic ers;
        logic prg;
        logic vpp;
    } err_t;

endpackage

// File: rtl/fci_decode.sv
module fci_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       kind
);
    always_comb begin
        case (code)
            OP_RD_ARRAY: kind = C_RD_ARRAY;
            OP_RD_STAT:  kind = C_RD_STAT;
            OP_RD_SIG:   kind = C_RD_SIG;
            OP_ERS_SET:  kind = C_ERS_SET;
            OP_PRG_SET:  kind = C_PRG_SET;
            OP_CONFIRM:  kind = C_CONFIRM;
            OP_CLR_STAT: kind = C_CLR_STAT;
            OP_SUSPEND:  kind = C_SUSPEND;
            default:     kind = C_NONE;
        endcase
    end
endmodule

// File: rtl/fci_pulse_timer.sv
module fci_pulse_timer #(
    parameter int PULSE_CYC = 4,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic             pulse_end,
    output logic [CNT_W-1:0] pulses
);
    localparam int CYC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PULSE_CYC - 1);

    logic [CYC_W-1:0] cyc;

    assign pulse_end = run && (cyc == CYC_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= '0;
            pulses <= '0;
        end else if (start) begin
            cyc    <= '0;
            pulses <= '0;
        end else if (run) begin
            if (pulse_end) begin
                cyc    <= '0;
                pulses <= pulses + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fci_wake_timer.sv
module fci_wake_timer #(
    parameter int CMD_WAKE  = 21,
    parameter int READ_WAKE = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic cmd_ok,
    output logic rd_ok
);
    localparam int W = $clog2(READ_WAKE + 1);
    localparam logic [W-1:0] CMD_LIM  = W'(CMD_WAKE);
    localparam logic [W-1:0] READ_LIM = W'(READ_WAKE);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= READ_LIM;
        else if (!pd_n)
            cnt <= '0;
        else if (cnt < READ_LIM)
            cnt <= cnt + 1'b1;
    end

    assign cmd_ok = pd_n && (cnt >= CMD_LIM);
    assign rd_ok  = pd_n && (cnt >= READ_LIM);
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int PULSE_CYC = 4,
    parameter int PROG_MAX  = 8,
    parameter int ERASE_MAX = 16,
    parameter int CMD_WAKE  = 21,
    parameter int READ_WAKE = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic       rd_stb,
    input  logic       vpp_low,
    input  logic       pd_n,
    input  logic       verify_ok,
    output logic [1:0] rd_sel,
    output logic [7:0] stat_o
);
    localparam int PMAX  = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
    localparam int CNT_W = $clog2(PMAX + 1);
    localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_MAX - 1);
    localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_MAX - 1);

    fsm_t   state, state_n;
    rmode_t mode, mode_n;
    err_t   err, err_n;
    cmd_t   cmd;

    logic             wk_cmd_ok, wk_rd_ok;
    logic             wr_ok, rd_ok;
    logic             t_start, t_end;
    logic [CNT_W-1:0] t_cnt;
    logic             busy;
    logic [7:0]       live;

    fci_decode u_dec (
        .code (cmd_data),
        .kind (cmd)
    );

    fci_wake_timer #(
        .CMD_WAKE  (CMD_WAKE),
        .READ_WAKE (READ_WAKE)
    ) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_n   (pd_n),
        .cmd_ok (wk_cmd_ok),
        .rd_ok  (wk_rd_ok)
    );

    assign busy = (state == S_PRUN) || (state == S_ERUN);

    fci_pulse_timer #(
        .PULSE_CYC (PULSE_CYC),
        .CNT_W     (CNT_W)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (t_start),
        .run       (busy),
        .pulse_end (t_end),
        .pulses    (t_cnt)
    );

    assign wr_ok = ce && cmd_we && wk_cmd_ok;
    assign rd_ok = ce && rd_stb && wk_rd_ok;

    // next-state and transition logic
    always_comb begin
        state_n = state;
        mode_n  = mode;
        err_n   = err;
        t_start = 1'b0;
        unique case (state)
            S_READY: begin
                if (wr_ok) begin
                    case (cmd)
                        C_RD_ARRAY: mode_n = RM_ARRAY;
                        C_RD_STAT:  mode_n = RM_STATUS;
                        C_RD_SIG:   mode_n = RM_SIG;
                        C_CLR_STAT: err_n  = '0;
                        C_PRG_SET: begin
                            state_n = S_PSET;
                            mode_n  = RM_STATUS;
                        end
                        C_ERS_SET: begin
                            state_n = S_ESET;
                            mode_n  = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            S_PSET: begin
                if (wr_ok) begin
                    mode_n = RM_STATUS;
                    if (vpp_low) begin
                        err_n.vpp = 1'b1;
                        state_n   = S_READY;
                    end else begin
                        state_n = S_PRUN;
                        t_start = 1'b1;
                    end
                end
            end
            S_ESET: begin
                if (wr_ok) begin
                    mode_n = RM_STATUS;
                    if (cmd != C_CONFIRM) begin
                        err_n.ers = 1'b1;
                        err_n.prg = 1'b1;
                        state_n   = S_READY;
                    end else if (vpp_low) begin
                        err_n.vpp = 1'b1;
                        state_n   = S_READY;
                    end else begin
                        state_n = S_ERUN;
                        t_start = 1'b1;
                    end
                end
            end
            S_PRUN: begin
                if (t_end && (verify_ok || (t_cnt == P_LAST))) begin
                    err_n.prg = !verify_ok;
                    state_n   = S_READY;
                end
            end
            S_ERUN: begin
                if (t_end && (verify_ok || (t_cnt == E_LAST))) begin
                    err_n.ers = !verify_ok;
                    state_n   = S_READY;
                end else if (wr_ok && (cmd == C_SUSPEND)) begin
                    state_n = S_ESUSP;
                end
            end
            S_ESUSP: begin
                if (wr_ok) begin
                    case (cmd)
                        C_CONFIRM: begin
                            state_n = S_ERUN;
                            mode_n  = RM_STATUS;
                        end
                        C_RD_ARRAY: mode_n = RM_ARRAY;
                        C_RD_STAT:  mode_n = RM_STATUS;
                        C_RD_SIG:   mode_n = RM_SIG;
                        default: ;
                    endcase
                end
            end
            S_SLEEP: begin
                state_n = S_READY;
                mode_n  = RM_ARRAY;
                err_n   = '0;
            end
            default: state_n = S_READY;
        endcase
        if (!pd_n) begin
            state_n = S_SLEEP;
            mode_n  = RM_ARRAY;
            err_n   = '0;
            t_start = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_READY;
            mode  <= RM_ARRAY;
            err   <= '0;
        end else begin
            state <= state_n;
            mode  <= mode_n;
            err   <= err_n;
        end
    end

    // outputs
    assign live   = {!busy, (state == S_ESUSP), err.ers, err.prg, err.vpp, 3'b000};
    assign rd_sel = mode;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_o <= 8'h80;
        else if (!pd_n)
            stat_o <= 8'h80;
        else if (rd_ok)
            stat_o <= live;
    end
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce,
    input logic       pd_n,
    input logic       cmd_we,
    input logic [1:0] rd_sel,
    input logic [7:0] stat_o,
    input logic       cmd_ok,
    input logic       busy
);
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[2:0] == 3'b000);

    a_r11_suspend_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[6] |-> stat_o[7]);

    a_r12_pd_forces_array: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (rd_sel == 2'd0 && stat_o == 8'h80));

    a_r14_ce_low_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && pd_n) |=> ($stable(rd_sel) && $stable(stat_o)));

    a_r13_early_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && ce && cmd_we && !cmd_ok) |=> $stable(rd_sel));

    a_r4_busy_in_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_sel == 2'd1));
endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (ce),
    .pd_n   (pd_n),
    .cmd_we (cmd_we),
    .rd_sel (rd_sel),
    .stat_o (stat_o),
    .cmd_ok (wk_cmd_ok),
    .busy   (busy)
);

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;
    localparam int PULSE_CYC = 4;
    localparam int PROG_MAX  = 8;
    localparam int ERASE_MAX = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b1;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic       vpp_low = 1'b0;
    logic       pd_n = 1'b1;
    logic       verify_ok = 1'b1;
    logic [1:0] rd_sel;
    logic [7:0] stat_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    flash_cmd_if #(
        .PULSE_CYC (PULSE_CYC),
        .PROG_MAX  (PROG_MAX),
        .ERASE_MAX (ERASE_MAX),
        .CMD_WAKE  (21),
        .READ_WAKE (30)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .cmd_we    (cmd_we),
        .cmd_data  (cmd_data),
        .rd_stb    (rd_stb),
        .vpp_low   (vpp_low),
        .pd_n      (pd_n),
        .verify_ok (verify_ok),
        .rd_sel    (rd_sel),
        .stat_o    (stat_o)
    );

    // command byte and expected read source after it, walked in order
    localparam logic [9:0] VEC [0:8] = '{
        {8'h70, 2'd1}, {8'h90, 2'd2}, {8'hB0, 2'd2}, {8'hD0, 2'd2},
        {8'hFF, 2'd0}, {8'h50, 2'd0}, {8'h90, 2'd2}, {8'hFF, 2'd0},
        {8'h70, 2'd1}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // all tasks start at a falling edge and end at the next one
    task automatic wr(input logic [7:0] b);
        cmd_we   = 1'b1;
        cmd_data = b;
        @(negedge clk);
        cmd_we   = 1'b0;
    endtask

    task automatic rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic poll_ready(input int limit);
        for (int i = 0; i < limit; i++) begin
            rd();
            if (stat_o[7]) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({6'd0, rd_sel}, 8'd0, "R1 rd_sel after reset");
        check(stat_o, 8'h80, "R1 status after reset");

        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][9:2]);
            check({6'd0, rd_sel}, {6'd0, VEC[i][1:0]}, "R2 read source vector");
        end

        // program, verify passes
        verify_ok = 1'b1;
        wr(8'h40); wr(8'h5A);
        check({6'd0, rd_sel}, 8'd1, "R4 status source after program");
        rd();
        check(stat_o, 8'h00, "R4 busy read during program (R3)");
        poll_ready(20);
        check(stat_o, 8'h80, "R4 program success");

        // program, verify always fails: exact completion edge
        verify_ok = 1'b0;
        wr(8'h40); wr(8'hA5);
        for (int i = 0; i < PROG_MAX * PULSE_CYC; i++) rd();
        check(stat_o, 8'h00, "R5 still busy at last pulse edge");
        rd();
        check(stat_o, 8'h90, "R5 program error");

        wr(8'h50);
        check({6'd0, rd_sel}, 8'd1, "R10 clear keeps source");
        rd();
        check(stat_o, 8'h80, "R10 errors cleared");

        // erase success
        verify_ok = 1'b1;
        wr(8'h20); wr(8'hD0);
        rd();
        check(stat_o, 8'h00, "R6 busy during erase");
        poll_ready(20);
        check(stat_o, 8'h80, "R6 erase success");

        // erase failure
        verify_ok = 1'b0;
        wr(8'h20); wr(8'hD0);
        poll_ready(ERASE_MAX * PULSE_CYC + 10);
        check(stat_o, 8'hA0, "R7 erase error");
        wr(8'h50);

        // bad confirm
        wr(8'hFF);
        wr(8'h20); wr(8'h33);
        check({6'd0, rd_sel}, 8'd1, "R8 status source after bad confirm");
        rd();
        check(stat_o, 8'hB0, "R8 both error bits");
        wr(8'h50); rd();
        check(stat_o, 8'h80, "R10 clear after sequence error");

        // suspend and resume
        verify_ok = 1'b0;
        wr(8'h20); wr(8'hD0); wr(8'hB0);
        rd();
        check(stat_o, 8'hC0, "R11 suspended and ready");
        repeat (200) @(negedge clk);
        rd();
        check(stat_o, 8'hC0, "R11 no pulse completes while suspended");
        wr(8'hD0);
        rd();
        check(stat_o, 8'h00, "R11 resume clears suspend and ready");
        verify_ok = 1'b1;
        poll_ready(40);
        check(stat_o, 8'h80, "R11 resumed erase completes");

        // supply fault, with chip enable low in between
        vpp_low = 1'b1;
        wr(8'h40); wr(8'h77);
        ce = 1'b0;
        wr(8'hFF);
        check({6'd0, rd_sel}, 8'd1, "R14 write ignored with ce low");
        rd();
        check(stat_o, 8'h80, "R14 read ignored with ce low");
        ce = 1'b1;
        rd();
        check(stat_o, 8'h88, "R9 supply fault, ready at once");
        vpp_low = 1'b0;

        // power-down
        pd_n = 1'b0;
        repeat (3) @(negedge clk);
        check({6'd0, rd_sel}, 8'd0, "R12 array source in power-down");
        check(stat_o, 8'h80, "R12 status in power-down");

        // wake-up: release sampled at edge F0
        pd_n = 1'b1;
        repeat (10) @(negedge clk);
        wr(8'h70);                       // edge F10
        check({6'd0, rd_sel}, 8'd0, "R13 early command ignored");
        repeat (13) @(negedge clk);
        wr(8'h70);                       // edge F24
        check({6'd0, rd_sel}, 8'd1, "R13 command accepted after wake");
        vpp_low = 1'b1;
        wr(8'h40); wr(8'h00);            // edges F25, F26
        vpp_low = 1'b0;
        rd();                            // edge F27
        check(stat_o, 8'h80, "R13 early read ignored");
        repeat (5) @(negedge clk);
        rd();                            // edge F33
        check(stat_o, 8'h88, "R12 errors cleared then new fault read");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule